// File: doc/BRIEF.md
# Serial CRC-4 Generator and Checker

This unit computes a 4-bit cyclic redundancy code one bit per clock with the generator polynomial D^4 + D + 1. A transfer begins with a one-cycle `start` pulse, which also samples `checkMode`. In generate mode the unit accepts 8 information bits, most significant first. It then presents the 4 check bits that the sender appends after the data, with `remainder[3]` sent first and `remainder[0]` sent last.

In check mode the unit accepts a 12-bit received block: 8 data bits followed by the 4 check bits, in line order. It divides the whole block by the polynomial and raises an error flag when the remainder is not zero. Both modes share one 4-bit shift register. The only difference is where the incoming bit enters: at the feedback for generation, which is the same as dividing the data with four zeros appended, or at the low end for plain division.

Top module: `crc4_serial_unit`

## Requirements
- R1: After reset, `remainder` is 0, `done` is 0 and `errFlag` is 0.
- R2: Each accepted bit updates `remainder` on the same clock edge. In generate mode, after k accepted bits it equals (prefix · D^4) mod (D^4+D+1). In check mode it equals prefix mod (D^4+D+1). The prefix is the k bits taken as a polynomial, first bit highest, and remainder bit i is the coefficient of D^i.
- R3: In generate mode, after 8 accepted bits `remainder` holds the checksum of the data. Data 1011 0110 gives 4'b1011.
- R4: In check mode, a 12-bit block that is divisible by the polynomial gives `errFlag` 0 while `done` is high. Examples are 1011 0110 1011 and 0000 1111 0010, and every block of 8 data bits followed by its own checksum.
- R5: In check mode, a block that is not divisible gives `errFlag` 1 and leaves the nonzero remainder on `remainder`. Examples are 1011 0010 1011, 1011 0110 1001 and 0000 0111 0010, and 0000 1111 1010, which leaves 4'b1000. Any single bit flip of a valid block is flagged.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the clock edge that accepts the 8th bit (generate) or the 12th bit (check).
- R7: `errFlag` is 0 whenever `done` is 0, and it is always 0 in generate mode.
- R8: `start` clears `remainder` and the bit count on the next edge in any state. A bit presented in the same cycle as `start` is ignored.
- R9: Cycles with `bitValid` low leave `remainder` unchanged.
- R10: After `done`, further valid bits are ignored until the next `start`. This also holds after reset before any `start`.
- R11: The mode is taken from `checkMode` only when `start` is high. Changing `checkMode` during a block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the unit and begins a block |
| checkMode | input | 1 | Sampled at start: 0 generate, 1 check |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | `bitIn` is accepted this cycle |
| remainder | output | 4 | Running remainder; bit 3 is the highest coefficient |
| done | output | 1 | One-cycle end-of-block pulse |
| errFlag | output | 1 | Nonzero remainder in check mode; meaningful only with done |

## Verification
The assertions assume that `start` is a single-cycle pulse and that bits arrive only after it. The hold property on `remainder` further assumes that idle cycles have both `start` and `bitValid` low. The stimulus always opens a block with a lone start cycle and then drives bits with `start` low. It sweeps every data byte in both modes and every single-bit corruption of each valid block. Gaps in `bitValid`, surplus bits after the end of a block, and mode toggles mid-block are applied only in dedicated sequences, each of which starts with a fresh start pulse.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  localparam int CRC_W      = 4;
  localparam int DATA_BITS  = 8;
  localparam int BLOCK_BITS = DATA_BITS + CRC_W;
  // low-order taps of D^4 + D + 1 (g1 = g0 = 1)
  localparam logic [CRC_W-1:0] POLY_LOW = 4'b0011;

  typedef struct packed {
    logic clear;
    logic shift;
    logic checkSel;
  } crcCtl_t;
endpackage

// File: rtl/crc4_control.sv
module crc4_control
  import crc4_pkg::*;
#(
  parameter int DATA_N  = DATA_BITS,
  parameter int BLOCK_N = BLOCK_BITS
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    checkMode,
  input  logic    bitValid,
  output crcCtl_t ctl,
  output logic    done
);
  localparam int CNT_W = $clog2(BLOCK_N + 1);
  localparam logic [CNT_W-1:0] GEN_LAST = CNT_W'(DATA_N - 1);
  localparam logic [CNT_W-1:0] CHK_LAST = CNT_W'(BLOCK_N - 1);

  logic [CNT_W-1:0] cntQ;
  logic armedQ, modeQ, doneQ;
  logic shiftNow, lastBit;

  assign shiftNow = armedQ && bitValid && !start;
  assign lastBit  = (cntQ == (modeQ ? CHK_LAST : GEN_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ   <= '0;
      armedQ <= 1'b0;
      modeQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else if (start) begin
      cntQ   <= '0;
      armedQ <= 1'b1;
      modeQ  <= checkMode;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (shiftNow) begin
        cntQ <= cntQ + 1'b1;
        if (lastBit) begin
          armedQ <= 1'b0;
          doneQ  <= 1'b1;
        end
      end
    end
  end

  assign ctl.clear    = start;
  assign ctl.shift    = shiftNow;
  assign ctl.checkSel = modeQ;
  assign done         = doneQ;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |=> !doneQ);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armedQ && !start) |=> ($stable(cntQ) && !armedQ));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(modeQ));
endmodule

// File: rtl/crc4_datapath.sv
module crc4_datapath
  import crc4_pkg::*;
#(
  parameter int               W    = CRC_W,
  parameter logic [W-1:0]     POLY = POLY_LOW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  crcCtl_t      ctl,
  input  logic         bitIn,
  output logic [W-1:0] rem
);
  logic [W-1:0] remQ, remNext;
  logic feedback;

  // generate: bit enters at the feedback (data times D^W);
  // check: bit enters at the low end (plain division)
  always_comb begin
    feedback = remQ[W-1] ^ (ctl.checkSel ? 1'b0 : bitIn);
    remNext  = {remQ[W-2:0], (ctl.checkSel ? bitIn : 1'b0)}
             ^ ({W{feedback}} & POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remQ <= '0;
    else if (ctl.clear) remQ <= '0;
    else if (ctl.shift) remQ <= remNext;
  end

  assign rem = remQ;
endmodule

// File: rtl/crc4_serial_unit.sv
module crc4_serial_unit
  import crc4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             checkMode,
  input  logic             bitIn,
  input  logic             bitValid,
  output logic [CRC_W-1:0] remainder,
  output logic             done,
  output logic             errFlag
);
  crcCtl_t ctl;

  crc4_control #(.DATA_N(DATA_BITS), .BLOCK_N(BLOCK_BITS)) uCtl (
    .clk(clk), .rst_n(rst_n), .start(start), .checkMode(checkMode),
    .bitValid(bitValid), .ctl(ctl), .done(done)
  );

  crc4_datapath #(.W(CRC_W), .POLY(POLY_LOW)) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .bitIn(bitIn), .rem(remainder)
  );

  assign errFlag = done && ctl.checkSel && (remainder != '0);

  // R7
  err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !errFlag);
  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (remainder == '0 && !done));
  // R9
  idle_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bitValid) |=> $stable(remainder));
  // R6
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bitValid));
endmodule

// File: tb/tb_crc4_serial_unit.sv
module tb_crc4_serial_unit;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, checkMode = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0;
  logic [3:0] remainder;
  logic done, errFlag;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  crc4_serial_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .checkMode(checkMode),
    .bitIn(bitIn), .bitValid(bitValid), .remainder(remainder),
    .done(done), .errFlag(errFlag)
  );

  function automatic logic [3:0] polyMod(input logic [15:0] v);
    logic [15:0] t = v;
    for (int i = 15; i >= 4; i--)
      if (t[i]) t = t ^ (16'h13 << (i - 4));
    return t[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic mode);
    @(negedge clk); start = 1'b1; checkMode = mode; bitValid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); start = 1'b0;
  endtask

  // sends n bits MSB first; optional idle gap after each bit; toggles mode pin if asked
  task automatic runBlock(input logic mode, input logic [11:0] bits, input int n,
                          input bit gaps, input bit wiggle);
    logic [15:0] prefix;
    logic [3:0] exp;
    pulseStart(mode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bitValid = 1'b1; bitIn = bits[n-1-k];
      if (wiggle) checkMode = ~checkMode;
      @(posedge clk); #1;
      prefix = 16'(bits >> (n - 1 - k));
      exp = mode ? polyMod(prefix) : polyMod(prefix << 4);
      chk(remainder == exp, "R2 running remainder", remainder, exp);
      if (k == n - 1) begin
        chk(done == 1'b1, "R6 done after last bit", done, 1);
        if (!mode) chk(errFlag == 1'b0, "R7 no error in generate", errFlag, 0);
        else chk(errFlag == (exp != 0), exp == 0 ? "R4 clean block" : "R5 corrupted block",
                 errFlag, exp != 0);
      end else begin
        chk(done == 1'b0, "R6 done early", done, 0);
      end
      if (gaps) begin
        @(negedge clk); bitValid = 1'b0;
        @(posedge clk); #1;
        chk(remainder == exp, "R9 idle hold", remainder, exp);
      end
    end
    @(negedge clk); bitValid = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0 && errFlag == 1'b0, "R6 R7 single pulse", {done, errFlag}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] cs;
    logic [3:0] held;
    repeat (3) @(posedge clk);
    #1;
    chk(remainder == 0 && done == 0 && errFlag == 0, "R1 reset state",
        {remainder, done, errFlag}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R10: bits before any start are ignored
    @(negedge clk); bitValid = 1'b1; bitIn = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(remainder == 0 && done == 0, "R10 ignored before start", remainder, 0);
    @(negedge clk); bitValid = 1'b0;

    // R3: stated generate vector
    runBlock(1'b0, 12'h0B6, 8, 1'b0, 1'b0);
    chk(remainder == 4'b1011, "R3 checksum of 1011 0110", remainder, 4'b1011);

    // R4/R5: stated receive vectors
    runBlock(1'b1, 12'b1011_0110_1011, 12, 1'b0, 1'b0);
    chk(remainder == 0, "R4 block 1011 0110 1011", remainder, 0);
    runBlock(1'b1, 12'b0000_1111_0010, 12, 1'b0, 1'b0);
    chk(remainder == 0, "R4 block 0000 1111 0010", remainder, 0);
    runBlock(1'b1, 12'b1011_0010_1011, 12, 1'b0, 1'b0);
    chk(remainder != 0, "R5 block 1011 0010 1011", remainder, 1);
    runBlock(1'b1, 12'b1011_0110_1001, 12, 1'b0, 1'b0);
    chk(remainder != 0, "R5 block 1011 0110 1001", remainder, 1);
    runBlock(1'b1, 12'b0000_0111_0010, 12, 1'b0, 1'b0);
    chk(remainder != 0, "R5 block 0000 0111 0010", remainder, 1);
    runBlock(1'b1, 12'b0000_1111_1010, 12, 1'b0, 1'b0);
    chk(remainder == 4'b1000, "R5 block 0000 1111 1010", remainder, 4'b1000);

    // exhaustive sweep: generate, then clean and every single-bit flip
    for (int d = 0; d < 256; d++) begin
      cs = polyMod(16'(d) << 4);
      runBlock(1'b0, 12'(d), 8, 1'b0, 1'b0);
      chk(remainder == cs, "R3 checksum sweep", remainder, cs);
      runBlock(1'b1, {8'(d), cs}, 12, 1'b0, 1'b0);
      for (int f = 0; f < 12; f++) begin
        runBlock(1'b1, {8'(d), cs} ^ (12'h1 << f), 12, 1'b0, 1'b0);
        chk(remainder != 0, "R5 single flip", remainder, 1);
      end
    end

    // R9: gaps between bits
    runBlock(1'b0, 12'h0B6, 8, 1'b1, 1'b0);
    chk(remainder == 4'b1011, "R9 gapped generate", remainder, 4'b1011);

    // R11: mode pin toggled mid-block
    runBlock(1'b0, 12'h0B6, 8, 1'b0, 1'b1);
    chk(remainder == 4'b1011, "R11 mode toggle ignored", remainder, 4'b1011);
    runBlock(1'b1, 12'b0000_1111_1010, 12, 1'b0, 1'b1);
    chk(remainder == 4'b1000, "R11 mode toggle in check", remainder, 4'b1000);

    // R10: surplus bits after done
    held = remainder;
    @(negedge clk); bitValid = 1'b1; bitIn = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk(remainder == held && done == 0, "R10 surplus bits ignored", remainder, held);
    @(negedge clk); bitValid = 1'b0;

    // R8: start mid-block, bit offered with start ignored
    pulseStart(1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bitValid = 1'b1; bitIn = 1'b1;
      @(posedge clk); #1;
    end
    @(negedge clk); start = 1'b1; checkMode = 1'b1; bitIn = 1'b1;
    @(posedge clk); #1;
    chk(remainder == 0 && done == 0, "R8 start clears", remainder, 0);
    @(negedge clk); start = 1'b0; bitValid = 1'b0;
    runBlock(1'b1, 12'b1011_0110_1011, 12, 1'b0, 1'b0);
    chk(remainder == 0, "R8 full block after restart", remainder, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule